// File: doc/BRIEF.md
# Bit-Maskable GPIO Bank Register File

This block holds the control and data registers for a single bank of up to 32 general-purpose pins behind a plain 32-bit register bus. The bus has a write strobe, a read strobe, a byte address and a data word. Read data comes back one cycle after the read strobe. The block drives a registered output value and a registered tri-state enable for every pin. It also returns the state of the pins, taken through a two-flop synchronizer.

The distinctive feature is the pair of masked-data write ports. Each one covers one 16-pin half of the bank. A single write updates any subset of that half's output latches and leaves the rest untouched, so software never needs a read-modify-write to toggle one pin. The upper half of the written word selects the pins that are protected from the update. The lower half carries the new values.

Direction and output-enable registers decide which pins are driven. A pin drives only when both its direction bit and its enable bit are set. Two pins of bank 0 are permanently outputs. A bank narrower than 32 pins reads zero in the missing bit positions and ignores writes to them.

Top module: `gpio_bank_regs`

## Requirements
- R1: A write to byte address 0x000 + 8*BANK_IDX updates pins 0..15: for each i in 0..15 with word bit 16+i equal to 0, the output latch of pin i takes word bit i. The new value appears on pin_out at the clock edge that accepts the write.
- R2: A write to byte address 0x004 + 8*BANK_IDX updates pins 16..31 in the same way: word bit 16+i protects pin 16+i, and word bit i is its new value.
- R3: In a masked-data write, a protect bit of 1 leaves that pin's output latch unchanged. Pins in the other half are never changed by the write.
- R4: Both masked-data addresses are write-only: a read of either returns 0.
- R5: A read of byte address 0x060 + 4*BANK_IDX returns the pin inputs after two synchronizer flops. A change that is stable before clock edge n is returned by a read whose capture edge is n+2 or later. A read captured at edge n+1 still returns the old value.
- R6: The direction register at byte address 0x204 + 0x40*BANK_IDX is read/write, with bit i = 1 meaning pin i is an output and 0 meaning an input.
- R7: The output-enable register at byte address 0x208 + 0x40*BANK_IDX is read/write. pin_oe[i] is 1 exactly when direction bit i and enable bit i were both 1 one clock earlier.
- R8: When BANK_IDX is 0, direction bits 7 and 8 read 1 from reset onward, whatever value is written to them.
- R9: Bit positions at or above NUM_PINS read as 0 in every register and ignore writes.
- R10: After a synchronous reset the output latches and the output-enable register are 0, the direction register holds only the bits locked by R8, and pin_oe is 0.
- R11: bus_rdata is registered. It carries the selected register one cycle after a read strobe, 0 for any address that is not a readable register, and 0 in a cycle that follows no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_rd_en | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Asynchronous pin input levels |
| pin_out | output | NUM_PINS | Output value latches |
| pin_oe | output | NUM_PINS | Per-pin tri-state enable, 1 = drive |

## Verification
A masked-data write is checked on pin_out at the falling edge that follows the accepting rising edge. pin_oe is checked one full cycle later, because it is registered from the direction and enable registers. Register reads are sampled at the falling edge after the capture edge. For the synchronizer, the bench reads once at the earliest edge, where the old value must still appear, and once after two edges, where the new value must appear. The bench runs with a 22-pin bank 0, so one configuration covers the locked pins, the missing upper bits and a high half that is only partly populated.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MASK_LO,
    SEL_MASK_HI,
    SEL_VALUE,
    SEL_DIR,
    SEL_OEN
  } reg_sel_e;

  // Byte offsets of the bank registers; the bank index spreads them.
  function automatic int unsigned offs_mask_lo(input int unsigned bank);
    return 32'h000 + 8 * bank;
  endfunction

  function automatic int unsigned offs_mask_hi(input int unsigned bank);
    return 32'h004 + 8 * bank;
  endfunction

  function automatic int unsigned offs_value(input int unsigned bank);
    return 32'h060 + 4 * bank;
  endfunction

  function automatic int unsigned offs_dir(input int unsigned bank);
    return 32'h204 + 32'h40 * bank;
  endfunction

  function automatic int unsigned offs_oen(input int unsigned bank);
    return 32'h208 + 32'h40 * bank;
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BANK_IDX = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  localparam logic [ADDR_W-1:0] A_MASK_LO = ADDR_W'(offs_mask_lo(BANK_IDX));
  localparam logic [ADDR_W-1:0] A_MASK_HI = ADDR_W'(offs_mask_hi(BANK_IDX));
  localparam logic [ADDR_W-1:0] A_VALUE   = ADDR_W'(offs_value(BANK_IDX));
  localparam logic [ADDR_W-1:0] A_DIR     = ADDR_W'(offs_dir(BANK_IDX));
  localparam logic [ADDR_W-1:0] A_OEN     = ADDR_W'(offs_oen(BANK_IDX));

  always_comb begin
    sel = SEL_NONE;
    if (addr == A_MASK_LO)      sel = SEL_MASK_LO;
    else if (addr == A_MASK_HI) sel = SEL_MASK_HI;
    else if (addr == A_VALUE)   sel = SEL_VALUE;
    else if (addr == A_DIR)     sel = SEL_DIR;
    else if (addr == A_OEN)     sel = SEL_OEN;
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  // Two flops per pin, each pin in its own generate scope.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_in[b];
        stab_q <= meta_q;
      end
    end
    assign sync_out[b] = stab_q;
  end

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [WORD_W-1:0]   wdata,
  output logic [NUM_PINS-1:0] latch_q
);

  logic [NUM_PINS-1:0] nxt;
  logic [NUM_PINS-1:0] protect;
  logic [NUM_PINS-1:0] want;

  always_comb begin
    nxt     = latch_q;
    protect = '1;
    want    = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      want[p] = wdata[p % HALF_W];
      if ((p < HALF_W && wr_lo) || (p >= HALF_W && wr_hi)) begin
        protect[p] = wdata[HALF_W + (p % HALF_W)];
        if (!protect[p]) nxt[p] = wdata[p % HALF_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) latch_q <= '0;
    else     latch_q <= nxt;
  end

  AST_PROTECTED_HOLD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((latch_q ^ $past(latch_q)) & $past(protect)) == '0); // R3

  AST_UNPROTECTED_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (wr_lo || wr_hi) |=> ((latch_q ^ $past(want)) & ~$past(protect)) == '0); // R1, R2

endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int BANK_IDX = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_dir,
  input  logic                wr_oen,
  input  logic [WORD_W-1:0]   wdata,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] oen_q,
  output logic [NUM_PINS-1:0] pin_oe_q
);

  function automatic logic [NUM_PINS-1:0] locked_bits();
    logic [NUM_PINS-1:0] v;
    v = '0;
    if (BANK_IDX == 0) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (i == 7 || i == 8) v[i] = 1'b1;
      end
    end
    return v;
  endfunction

  localparam logic [NUM_PINS-1:0] LOCKED = locked_bits();

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q    <= LOCKED;
      oen_q    <= '0;
      pin_oe_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata[NUM_PINS-1:0] | LOCKED;
      if (wr_oen) oen_q <= wdata[NUM_PINS-1:0];
      pin_oe_q <= dir_q & oen_q;
    end
  end

  if (BANK_IDX == 0 && NUM_PINS > 8) begin : g_lock_chk
    AST_LOCKED_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
      dir_q[7] && dir_q[8]); // R8
  end

  AST_OE_NEEDS_DIR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pin_oe_q & ~$past(dir_q)) == '0); // R7

  AST_OE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pin_oe_q & ~$past(oen_q)) == '0); // R7

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int BANK_IDX = 0,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr_en,
  input  logic                bus_rd_en,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);

  reg_sel_e            sel;
  logic [NUM_PINS-1:0] pins_sync;
  logic [NUM_PINS-1:0] dir_q;
  logic [NUM_PINS-1:0] oen_q;

  gpio_addr_decode #(.ADDR_W(ADDR_W), .BANK_IDX(BANK_IDX)) i_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  gpio_in_sync #(.WIDTH(NUM_PINS)) i_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (pins_sync)
  );

  gpio_out_latch #(.NUM_PINS(NUM_PINS)) i_latch (
    .clk     (clk),
    .rst     (rst),
    .wr_lo   (bus_wr_en && sel == SEL_MASK_LO),
    .wr_hi   (bus_wr_en && sel == SEL_MASK_HI),
    .wdata   (bus_wdata),
    .latch_q (pin_out)
  );

  gpio_ctrl_regs #(.NUM_PINS(NUM_PINS), .BANK_IDX(BANK_IDX)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_dir   (bus_wr_en && sel == SEL_DIR),
    .wr_oen   (bus_wr_en && sel == SEL_OEN),
    .wdata    (bus_wdata),
    .dir_q    (dir_q),
    .oen_q    (oen_q),
    .pin_oe_q (pin_oe)
  );

  // Registered read path; write-only and unknown addresses return zero.
  always_ff @(posedge clk) begin
    if (rst || !bus_rd_en) begin
      bus_rdata <= '0;
    end else begin
      unique case (sel)
        SEL_VALUE: bus_rdata <= WORD_W'(pins_sync);
        SEL_DIR:   bus_rdata <= WORD_W'(dir_q);
        SEL_OEN:   bus_rdata <= WORD_W'(oen_q);
        default:   bus_rdata <= '0;
      endcase
    end
  end

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_en |=> bus_rdata == '0); // R11

  AST_WRITE_ONLY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && (sel == SEL_MASK_LO || sel == SEL_MASK_HI)) |=> bus_rdata == '0); // R4

  if (NUM_PINS < WORD_W) begin : g_unimpl_chk
    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst)
      bus_rd_en |=> bus_rdata[WORD_W-1:NUM_PINS] == '0); // R9
  end

endmodule

// File: tb/test_gpio_bank_regs.sv
module test_gpio_bank_regs;

  localparam int  NP     = 22;
  localparam int  AW     = 12;
  localparam time CLK_PD = 10;
  localparam logic [AW-1:0] A_LO  = 12'h000;
  localparam logic [AW-1:0] A_HI  = 12'h004;
  localparam logic [AW-1:0] A_VAL = 12'h060;
  localparam logic [AW-1:0] A_DIR = 12'h204;
  localparam logic [AW-1:0] A_OEN = 12'h208;
  localparam logic [NP-1:0] LOCK  = 22'h000180;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;

  int n_run  = 0;
  int n_fail = 0;
  logic [NP-1:0] m_out = '0;
  logic [NP-1:0] m_dir = LOCK;
  logic [NP-1:0] m_oen = '0;
  logic [31:0]   rd_v;

  always #(CLK_PD / 2) clk = ~clk;

  gpio_bank_regs #(.NUM_PINS(NP), .BANK_IDX(0), .ADDR_W(AW)) i_gpio_bank_regs (
    .clk(clk), .rst(rst), .bus_wr_en(wr_en), .bus_rd_en(rd_en),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // Model of a masked write to one half of the bank.
  task automatic model_masked(input bit hi, input logic [31:0] d);
    for (int i = 0; i < 16; i++) begin
      int p = hi ? i + 16 : i;
      if (p < NP && !d[16+i]) m_out[p] = d[i];
    end
  endtask

  initial begin
    #(CLK_PD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 / R8: reset state
    chk("R10 pin_out reset", 32'(pin_out), 32'h0);
    chk("R10 pin_oe reset", 32'(pin_oe), 32'h0);
    rd(A_DIR, rd_v); chk("R8 R10 dir reset", rd_v, 32'(LOCK));
    rd(A_OEN, rd_v); chk("R10 oen reset", rd_v, 32'h0);

    // R1: single-pin sweep of the low half, garbage in protected data bits
    for (int v = 0; v < 2; v++) begin
      for (int p = 0; p < 16; p++) begin
        logic [31:0] d;
        d = {~(16'(1) << p), 16'hA5C3};
        d[p] = v[0];
        wr(A_LO, d); model_masked(1'b0, d);
        chk("R1 low half pin", 32'(pin_out), 32'(m_out));
      end
    end

    // R2 / R9: sweep of the high half, including missing pins 22..31
    for (int v = 0; v < 2; v++) begin
      for (int p = 0; p < 16; p++) begin
        logic [31:0] d;
        d = {~(16'(1) << p), 16'h3C5A};
        d[p] = v[0];
        wr(A_HI, d); model_masked(1'b1, d);
        chk(p < NP - 16 ? "R2 high half pin" : "R9 missing pin", 32'(pin_out), 32'(m_out));
      end
    end

    // R3: fully protected writes change nothing
    wr(A_LO, 32'hFFFF_FFFF); chk("R3 all protected low", 32'(pin_out), 32'(m_out));
    wr(A_HI, 32'hFFFF_0000); chk("R3 all protected high", 32'(pin_out), 32'(m_out));

    // R3: mixed protect patterns, arithmetic model
    for (int k = 0; k < 16; k++) begin
      logic [15:0] msk;
      logic [15:0] dat;
      logic [31:0] d;
      msk = 16'(k * 16'h1111) ^ 16'h0F0F;
      dat = 16'(k * 16'h3B27 + 16'h1234);
      d = {msk, dat};
      wr(k[0] ? A_HI : A_LO, d);
      model_masked(k[0], d);
      chk("R3 mixed protect", 32'(pin_out), 32'(m_out));
    end

    // R4: write-only registers read zero
    rd(A_LO, rd_v); chk("R4 low masked read", rd_v, 32'h0);
    rd(A_HI, rd_v); chk("R4 high masked read", rd_v, 32'h0);

    // R6 / R8 / R9: direction write patterns
    for (int k = 0; k < 8; k++) begin
      logic [31:0] d;
      d = 32'(k) * 32'h2492_4925 ^ 32'hFFFF_0000;
      wr(A_DIR, d);
      m_dir = d[NP-1:0] | LOCK;
      rd(A_DIR, rd_v); chk("R6 R8 dir readback", rd_v, 32'(m_dir));
    end
    wr(A_DIR, 32'h0); rd(A_DIR, rd_v); chk("R8 locked after zero write", rd_v, 32'(LOCK));
    m_dir = LOCK;

    // R7: output enable and pin_oe one cycle after the register
    for (int k = 0; k < 8; k++) begin
      logic [31:0] dd;
      logic [31:0] oe;
      dd = 32'(k) * 32'h1357_9BDF;
      oe = 32'(k) * 32'h2468_ACE1 ^ 32'h00F0_F0F0;
      wr(A_DIR, dd); m_dir = dd[NP-1:0] | LOCK;
      wr(A_OEN, oe); m_oen = oe[NP-1:0];
      rd(A_OEN, rd_v); chk("R7 R9 oen readback", rd_v, 32'(m_oen));
      chk("R7 pin_oe", 32'(pin_oe), 32'(m_dir & m_oen));
    end
    wr(A_OEN, 32'hFFFF_FFFF);
    chk("R7 pin_oe before update", 32'(pin_oe), 32'(m_dir & m_oen));
    m_oen = '1;
    @(negedge clk);
    chk("R7 pin_oe after update", 32'(pin_oe), 32'(m_dir & m_oen));

    // R5: synchronizer timing and value patterns
    for (int k = 0; k < 6; k++) begin
      logic [NP-1:0] old_v;
      logic [NP-1:0] new_v;
      old_v = pin_in;
      new_v = NP'(k * 32'h0009_1A2B + 32'h0015_5555);
      pin_in = new_v;
      rd(A_VAL, rd_v); chk("R5 early read old", rd_v, 32'(old_v));
      rd(A_VAL, rd_v); chk("R5 settled read", rd_v, 32'(new_v));
    end

    // R11: unknown address and idle cycle read zero
    rd(12'h100, rd_v); chk("R11 unknown addr", rd_v, 32'h0);
    rd(A_DIR, rd_v);
    @(negedge clk); chk("R11 idle rdata", rdata, 32'h0);

    finish_run();
  end

endmodule